// File: doc/BRIEF.md
# Gated Carrier Divider Waveform Timer

This block divides an externally supplied carrier into a slower square wave and a helper pulse. A 16-bit up-counter advances once for each rising edge of the carrier input, sampled in the system clock domain. It runs from zero up to a programmable divisor and then wraps. Three compare values drive two waveform outputs. The divided carrier (`wave_a`) rises at one compare value and falls at the divisor. The helper output (`wave_b`) rises on an external event edge and falls at a second compare value. A software trigger restarts the counter and clears both outputs.

Counting can be gated by a burst input. When gating is enabled and the burst input is low, carrier edges are dropped and the counter holds its value. When the divisor is changed while the count is already beyond the new value, a small reload controller keeps the carrier phase. It waits for the count to fall to a low mark before loading the new divisor. If the count still lies above the new divisor after the load, it waits for the count to reach a multiple of that divisor and then restarts the counter. These waits are skipped while the counter is frozen by the gate.

Top module: `carrier_divider_timer`

## Requirements
- R1: The counter advances by one on each synchronized rising edge of `carrier_in` (two-flop synchronizer, so the count changes on the third clock edge after the input rises). A carrier edge that arrives while the count equals the divisor sets the count to 0. The divisor resets to 128.
- R2: `wave_a` goes high when the count reaches the RA compare value and goes low when it reaches the divisor. The divisor wins if both match.
- R3: `wave_b` goes high one clock after a synchronized rising edge of `event_in` and goes low when the count reaches the RB compare value. The event wins if both occur in the same cycle.
- R4: A high `sw_trig` (or an internal trigger from the reload controller) sets the count to 0 and drives both waveform outputs low on the next clock edge.
- R5: When gate enable is 1 and the synchronized `gate_in` is 0, carrier edges leave the count unchanged. When gate enable is 0, `gate_in` has no effect.
- R6: A compare value greater than the divisor never sets its output, even when the count passes that value.
- R7: A divisor write of value d while the count is above d raises `reload_busy`. The divisor is loaded only once the count is 3 or less.
- R8: If the count exceeds the divisor right after the load, the controller waits until the count is 0 or a multiple of the divisor. It then restarts the counter as in R4 and drops `reload_busy`.
- R9: While gate enable is 1 and `gate_in` is 0, a divisor write loads at once without either wait and leaves the count unchanged. A later count may then exceed the divisor and keep rising.
- R10: A divisor write of value 0, or any divisor write while `reload_busy` is high, is ignored.
- R11: Register select `wr_sel` picks a target: 0 = RA (reset 64), 1 = RB (reset 16), 2 = divisor, 3 = gate enable (bit 0 of `wr_data`, reset 0). RA, RB and gate enable take effect on the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| carrier_in | input | 1 | Carrier to be divided, asynchronous |
| gate_in | input | 1 | Burst gate, asynchronous, high allows counting |
| event_in | input | 1 | External event, rising edge sets `wave_b` |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see R11) |
| wr_data | input | 16 | Write data |
| sw_trig | input | 1 | Software trigger, one clock pulse |
| wave_a | output | 1 | Divided carrier output |
| wave_b | output | 1 | Helper pulse output |
| count_o | output | 16 | Current counter value |
| reload_busy | output | 1 | Divisor reload in progress |

## Verification
A wrong count shows on `count_o` on the clock after the carrier edge that caused it. The compare outputs show it within one carrier period, as a waveform edge at the wrong count or no edge at all. A reload controller stuck in a wait state is visible at once as `reload_busy` that never drops. A divisor loaded too early or never loaded shows up as a wrap at the wrong count on the next pass through the top of the range. A missing phase restart shows as a count that keeps climbing past the new divisor instead of returning to 0.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    typedef enum logic [1:0] {
        RL_IDLE     = 2'd0,
        RL_WAIT_LOW = 2'd1,
        RL_CHECK    = 2'd2,
        RL_WAIT_MOD = 2'd3
    } rl_state_e;

    localparam logic [1:0] SEL_RA   = 2'd0;
    localparam logic [1:0] SEL_RB   = 2'd1;
    localparam logic [1:0] SEL_DIV  = 2'd2;
    localparam logic [1:0] SEL_GATE = 2'd3;
endpackage

// File: rtl/cdt_edge_sync.sv
module cdt_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign level_o = sy_q.s2;
    assign rise_o  = sy_q.s2 & ~sy_q.s3;
endmodule

// File: rtl/cdt_wave_counter.sv
module cdt_wave_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         gate_block,
    input  logic         ev_rise,
    input  logic         trig,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] rc,
    output logic [W-1:0] cnt,
    output logic         wave_a,
    output logic         wave_b
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         a;
        logic         b;
    } wc_t;

    wc_t wc_d, wc_q;
    logic         adv;
    logic [W-1:0] nxt;

    always_comb begin
        wc_d = wc_q;
        adv  = tick & ~gate_block;
        nxt  = (wc_q.cnt == rc) ? '0 : wc_q.cnt + 1'b1;
        if (trig) begin
            wc_d.cnt = '0;
            wc_d.a   = 1'b0;
            wc_d.b   = 1'b0;
        end else begin
            if (adv) begin
                wc_d.cnt = nxt;
                if (nxt == rc)                     wc_d.a = 1'b0;
                else if (nxt == ra && ra <= rc)    wc_d.a = 1'b1;
                if (nxt == rb && rb <= rc)         wc_d.b = 1'b0;
            end
            if (ev_rise) wc_d.b = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wc_q <= '0;
        else        wc_q <= wc_d;
    end

    assign cnt    = wc_q.cnt;
    assign wave_a = wc_q.a;
    assign wave_b = wc_q.b;

    // R4
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (cnt == '0 && !wave_a && !wave_b));

    // R1
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !gate_block && !trig && cnt == rc) |=> (cnt == '0));

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_block && !trig) |=> $stable(cnt));

    // R6
    above_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wave_a) |-> ($past(ra) <= $past(rc) && cnt == $past(ra)));

    // R2
    a_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wave_a) && !$past(trig)) |-> (cnt == $past(rc)));
endmodule

// File: rtl/cdt_div_reload.sv
module cdt_div_reload
    import cdt_pkg::*;
#(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_DIV = 16'd128,
    parameter int          LOW_MARK = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_div,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cnt,
    input  logic         gate_block,
    output logic [W-1:0] rc,
    output logic         busy,
    output logic         trig
);
    localparam logic [W-1:0] LOW_V = W'(LOW_MARK);

    typedef struct packed {
        rl_state_e    state;
        logic [W-1:0] rc;
        logic [W-1:0] pend;
        logic [W:0]   mult;
    } rl_t;

    rl_t rl_d, rl_q;

    always_comb begin
        rl_d = rl_q;
        trig = 1'b0;
        case (rl_q.state)
            RL_IDLE: begin
                if (wr_div && wr_val != '0) begin
                    if (!gate_block && cnt > wr_val) begin
                        rl_d.pend  = wr_val;
                        rl_d.state = RL_WAIT_LOW;
                    end else begin
                        rl_d.rc    = wr_val;
                        rl_d.state = RL_CHECK;
                    end
                end
            end
            RL_WAIT_LOW: begin
                if (cnt <= LOW_V) begin
                    rl_d.rc    = rl_q.pend;
                    rl_d.state = RL_CHECK;
                end
            end
            RL_CHECK: begin
                if (!gate_block && cnt > rl_q.rc) begin
                    rl_d.mult  = {1'b0, rl_q.rc};
                    rl_d.state = RL_WAIT_MOD;
                end else begin
                    rl_d.state = RL_IDLE;
                end
            end
            default: begin
                if ({1'b0, cnt} == rl_q.mult || cnt == '0) begin
                    trig       = 1'b1;
                    rl_d.state = RL_IDLE;
                end else if ({1'b0, cnt} > rl_q.mult) begin
                    rl_d.mult = rl_q.mult + {1'b0, rl_q.rc};
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rl_q       <= '0;
            rl_q.state <= RL_IDLE;
            rl_q.rc    <= RST_DIV;
        end else begin
            rl_q <= rl_d;
        end
    end

    assign rc   = rl_q.rc;
    assign busy = (rl_q.state != RL_IDLE);

    // R7
    low_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_q.state == RL_WAIT_LOW && cnt > LOW_V) |=> ($stable(rc) && busy));

    // R8
    mod_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_q.state == RL_WAIT_MOD) |=> $stable(rc));

    // R10
    zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_div && wr_val == '0) |=> (!busy && $stable(rc)));
endmodule

// File: rtl/carrier_divider_timer.sv
module carrier_divider_timer
    import cdt_pkg::*;
#(
    parameter int           W      = 16,
    parameter logic [W-1:0] RST_RA = 16'd64,
    parameter logic [W-1:0] RST_RB = 16'd16,
    parameter logic [W-1:0] RST_RC = 16'd128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         carrier_in,
    input  logic         gate_in,
    input  logic         event_in,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         sw_trig,
    output logic         wave_a,
    output logic         wave_b,
    output logic [W-1:0] count_o,
    output logic         reload_busy
);
    typedef struct packed {
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic         gate_en;
    } regs_t;

    regs_t rg_d, rg_q;

    logic         car_lvl, car_rise;
    logic         gate_lvl, gate_rise;
    logic         ev_lvl, ev_rise;
    logic         gate_block;
    logic         rl_trig;
    logic         trig_all;
    logic [W-1:0] rc;
    logic [W-1:0] cnt;

    cdt_edge_sync u_car (.clk(clk), .rst_n(rst_n), .async_i(carrier_in),
                         .level_o(car_lvl), .rise_o(car_rise));
    cdt_edge_sync u_gate (.clk(clk), .rst_n(rst_n), .async_i(gate_in),
                          .level_o(gate_lvl), .rise_o(gate_rise));
    cdt_edge_sync u_ev (.clk(clk), .rst_n(rst_n), .async_i(event_in),
                        .level_o(ev_lvl), .rise_o(ev_rise));

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_RA:   rg_d.ra      = wr_data;
                SEL_RB:   rg_d.rb      = wr_data;
                SEL_GATE: rg_d.gate_en = wr_data[0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q.ra      <= RST_RA;
            rg_q.rb      <= RST_RB;
            rg_q.gate_en <= 1'b0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign gate_block = rg_q.gate_en & ~gate_lvl;
    assign trig_all   = sw_trig | rl_trig;

    cdt_div_reload #(.W(W), .RST_DIV(RST_RC), .LOW_MARK(3)) u_reload (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_div     (wr_en && wr_sel == SEL_DIV),
        .wr_val     (wr_data),
        .cnt        (cnt),
        .gate_block (gate_block),
        .rc         (rc),
        .busy       (reload_busy),
        .trig       (rl_trig)
    );

    cdt_wave_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (car_rise),
        .gate_block (gate_block),
        .ev_rise    (ev_rise),
        .trig       (trig_all),
        .ra         (rg_q.ra),
        .rb         (rg_q.rb),
        .rc         (rc),
        .cnt        (cnt),
        .wave_a     (wave_a),
        .wave_b     (wave_b)
    );

    assign count_o = cnt;

    // R3
    b_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wave_b) |-> $past(ev_rise));

    // R11
    gate_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_GATE) |=> (rg_q.gate_en == $past(wr_data[0])));
endmodule

// File: tb/tb_carrier_divider_timer.sv
module tb_carrier_divider_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        carrier_in = 1'b0;
    logic        gate_in = 1'b1;
    logic        event_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = '0;
    logic        sw_trig = 1'b0;
    logic        wave_a, wave_b, reload_busy;
    logic [15:0] count_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    carrier_divider_timer dut (
        .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .gate_in(gate_in),
        .event_in(event_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .sw_trig(sw_trig), .wave_a(wave_a), .wave_b(wave_b), .count_o(count_o),
        .reload_busy(reload_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            carrier_in = 1'b1; idle(3);
            carrier_in = 1'b0; idle(3);
        end
    endtask

    task automatic trig();
        @(negedge clk); sw_trig = 1'b1;
        @(negedge clk); sw_trig = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40 && reload_busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        idle(1);
        chk("R1 reset count", count_o, 0);
        chk("R4 reset wave_a", wave_a, 0);
        chk("R4 reset wave_b", wave_b, 0);
        chk("R7 reset busy", reload_busy, 0);
    endtask

    task automatic t_default();
        pulse(64);
        chk("R11 default RA sets wave_a", wave_a, 1);
        chk("R1 count 64", count_o, 64);
        pulse(64);
        chk("R1 count 128", count_o, 128);
        chk("R2 divisor clears wave_a", wave_a, 0);
        pulse(1);
        chk("R1 default divisor wraps", count_o, 0);
    endtask

    task automatic t_basic();
        wr(2'd0, 16'd2);
        wr(2'd2, 16'd5);
        wait_idle();
        trig();
        pulse(1);
        chk("R2 below RA", wave_a, 0);
        pulse(1);
        chk("R2 RA match sets", wave_a, 1);
        pulse(3);
        chk("R1 count 5", count_o, 5);
        chk("R2 divisor clears", wave_a, 0);
        pulse(1);
        chk("R1 wrap after divisor", count_o, 0);
    endtask

    task automatic t_event();
        wr(2'd1, 16'd3);
        trig();
        event_in = 1'b1; idle(4);
        chk("R3 event sets wave_b", wave_b, 1);
        event_in = 1'b0; idle(2);
        pulse(2);
        chk("R3 held before RB", wave_b, 1);
        pulse(1);
        chk("R3 RB clears wave_b", wave_b, 0);
    endtask

    task automatic t_trig();
        event_in = 1'b1; idle(4); event_in = 1'b0; idle(2);
        chk("R4 pre wave_a", wave_a, 1);
        chk("R4 pre wave_b", wave_b, 1);
        trig();
        chk("R4 trig count", count_o, 0);
        chk("R4 trig wave_a", wave_a, 0);
        chk("R4 trig wave_b", wave_b, 0);
    endtask

    task automatic t_above();
        int seen = 0;
        wr(2'd0, 16'd7);
        trig();
        for (int i = 0; i < 7; i++) begin
            pulse(1);
            if (wave_a) seen = 1;
        end
        chk("R6 compare above divisor never fires", seen, 0);
        chk("R6 count after period", count_o, 1);
        wr(2'd0, 16'd2);
    endtask

    task automatic t_reload_wait();
        trig();
        pulse(4);
        wr(2'd2, 16'd2);
        chk("R7 busy raised", reload_busy, 1);
        wr(2'd2, 16'd4);
        pulse(1);
        chk("R7 old divisor still used", count_o, 5);
        chk("R7 still waiting", reload_busy, 1);
        pulse(1);
        chk("R7 wrap at old divisor", count_o, 0);
        wait_idle();
        chk("R7 busy dropped", reload_busy, 0);
        pulse(2);
        chk("R7 count 2", count_o, 2);
        pulse(1);
        chk("R10 busy write ignored, wraps at 2", count_o, 0);
    endtask

    task automatic t_reload_mod();
        wr(2'd2, 16'd5);
        wait_idle();
        trig();
        pulse(3);
        chk("R8 pre wave_a", wave_a, 1);
        wr(2'd2, 16'd1);
        wait_idle();
        chk("R8 busy done", reload_busy, 0);
        chk("R8 restart count", count_o, 0);
        chk("R8 restart wave_a", wave_a, 0);
        pulse(1);
        chk("R8 count 1", count_o, 1);
        pulse(1);
        chk("R8 wraps at new divisor", count_o, 0);
    endtask

    task automatic t_gate();
        wr(2'd2, 16'd5);
        wait_idle();
        trig();
        pulse(4);
        wr(2'd3, 16'd1);
        gate_in = 1'b0; idle(4);
        pulse(1);
        chk("R5 gated carrier ignored", count_o, 4);
        wr(2'd2, 16'd2);
        wait_idle();
        chk("R9 load immediate", reload_busy, 0);
        chk("R9 count untouched", count_o, 4);
        gate_in = 1'b1; idle(4);
        pulse(1);
        chk("R9 counts past divisor", count_o, 5);
        wr(2'd3, 16'd0);
        gate_in = 1'b0; idle(4);
        pulse(1);
        chk("R5 gate ignored when disabled", count_o, 6);
        trig();
        pulse(2);
        chk("R9 count 2", count_o, 2);
        pulse(1);
        chk("R9 new divisor in use", count_o, 0);
        gate_in = 1'b1; idle(4);
    endtask

    task automatic t_zero();
        wr(2'd2, 16'd0);
        idle(2);
        chk("R10 zero write not busy", reload_busy, 0);
        trig();
        pulse(3);
        chk("R10 zero write ignored", count_o, 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        t_reset();
        t_default();
        t_basic();
        t_event();
        t_trig();
        t_above();
        t_reload_wait();
        t_reload_mod();
        t_gate();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule